// File: doc/BRIEF.md
# Synchronous REQ Offset Pacer

This block drives the target-side REQ strobe for a data phase run in synchronous mode. Bytes arrive on a valid/ready stream. Each accepted byte is placed on the outgoing data lines, held there for a programmed setup time, and then announced with one REQ pulse. The initiator answers every REQ pulse with one ACK pulse. The pacer counts the REQ pulses that have not yet been acknowledged and never lets that count exceed the negotiated window. A window of zero selects asynchronous handshaking, which this block does not serve, so the block reports a mode error instead. A window of 0xFF removes the limit.

The spacing of REQ edges is set by four cycle counts and one period. The high time of each pulse comes from the assertion count. The low time comes from the negation count. The rise-to-rise spacing comes from the negotiated transfer period, which is given in 4 ns units and converted to clock cycles with the `CLK_PS` parameter. The data setup and hold counts decide when a byte may be loaded and when REQ may rise.

Stream rules: `in_ready` depends only on internal state, never on `in_valid`. A byte is taken on a cycle with both `in_valid` and `in_ready` high; that handshake is the block's load strobe. The source may hold `in_valid` low for any length of time. `in_last` marks the final byte of the phase. The ACK input is asynchronous and is synchronized inside the block.

Top module: `sync_req_pacer`

## Requirements
- R1: When `cfg_offset` is between 1 and 254, `outstanding` never exceeds `cfg_offset`. At that limit no REQ rises until a further ACK pulse has been counted.
- R2: While `enable` is high and `cfg_offset` is 0, `in_ready` stays low and REQ never rises. `mode_err` reads 1 from the next cycle on.
- R3: With `cfg_offset` = 0xFF, REQ pulses keep being issued with no ACK at all, and `outstanding` climbs to the number issued.
- R4: Every REQ pulse is high for exactly max(`cfg_assert`,1) cycles.
- R5: A REQ rise comes no sooner than max(period cycles,1) cycles after the previous rise, and no sooner than max(`cfg_negate`,1) cycles after the previous fall. With an unlimited window and a source that always has data, the rise-to-rise gap is exactly the largest of three values: max(S+H,1)+max(S,1), max(P,1) and max(A,1)+max(N,1). Here S, H, A and N are the setup, hold, assert and negate counts, and P is the period in cycles.
- R6: The period in cycles is ceil(`cfg_period` × 4000 / `CLK_PS`), saturated at the counter range.
- R7: `done` is high only after the byte marked `in_last` has had its REQ, every REQ has been matched by a counted ACK, and REQ is low.
- R8: `db_out` changes only when a byte is loaded. It is stable for at least `cfg_setup` cycles before a REQ rise and for at least `cfg_setup`+`cfg_hold` cycles after it. The n-th REQ of a phase presents the n-th accepted byte.
- R9: A rising ACK edge is counted two cycles after it is sampled. A REQ issue and an ACK count in the same cycle leave `outstanding` unchanged. At the end of a phase, `outstanding` equals the REQ pulses issued minus the ACKs counted.
- R10: An ACK edge counted while `outstanding` is 0 (with no REQ issued that cycle) sets `proto_err` and is discarded. Dropping `enable` clears `proto_err` and `outstanding`.
- R11: `in_ready` is high only while enabled in a synchronous window, with no byte waiting for its REQ, and once the hold time after the last REQ rise has passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Data phase active; low clears phase state |
| cfg_offset | input | 8 | Negotiated window (0 = async, 0xFF = unlimited) |
| cfg_period | input | 8 | Negotiated transfer period in 4 ns units |
| cfg_assert | input | TW | Minimum REQ high time in cycles |
| cfg_negate | input | TW | Minimum REQ low time in cycles |
| cfg_setup | input | TW | Data-to-REQ setup in cycles (deskew plus cable skew) |
| cfg_hold | input | TW | Extra hold after REQ rise in cycles |
| in_valid | input | 1 | Source has a byte |
| in_ready | output | 1 | Pacer can take a byte |
| in_data | input | 8 | Byte to send |
| in_last | input | 1 | Byte is the final one of the phase |
| ack_in | input | 1 | Asynchronous ACK from the initiator |
| req_out | output | 1 | REQ strobe |
| db_out | output | 8 | Byte on the data lines |
| done | output | 1 | Phase complete with balanced REQ/ACK |
| outstanding | output | CNT_W | REQ pulses not yet acknowledged |
| mode_err | output | 1 | Enabled with an asynchronous window |
| proto_err | output | 1 | ACK received with nothing outstanding |

## Verification
The bench sweeps small windows, pulse widths, setup and hold counts, odd and even period codes, and fast or slow ACK responses. It checks every REQ edge against the arithmetic rules. If the period conversion rounded down, or a spacing term were added instead of taken as a maximum, the exact rise-to-rise check in unlimited mode would catch it. A window off by one would show as a third REQ with two outstanding when ACKs are withheld. An orphan ACK that still decremented, or a missing error flag, would show on `outstanding` and `proto_err`. A `done` raised before the final ACK was counted would be caught while ACKs are held back.

// File: rtl/pacer_pkg.sv
package pacer_pkg;

  // Picoseconds in one unit of the negotiated period code.
  localparam int unsigned STEP_PS = 4000;

  // Slots of the elapsed-time counters.
  localparam int SINCE_RISE = 0;
  localparam int SINCE_FALL = 1;
  localparam int SINCE_LOAD = 2;
  localparam int N_SINCE    = 3;

  localparam logic [7:0] WIN_ASYNC = 8'h00;
  localparam logic [7:0] WIN_UNLIM = 8'hFF;

  // Rounds the period up to whole clock cycles.
  function automatic int unsigned period_to_cycles(input logic [7:0] units,
                                                   input int unsigned clk_ps);
    int unsigned ps;
    ps = {24'd0, units} * STEP_PS;
    return (ps + clk_ps - 1) / clk_ps;
  endfunction

endpackage

// File: rtl/pacer_ack_sync.sv
module pacer_ack_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_async,
  output logic ack_edge
);
  logic [STAGES:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-1:0], ack_async};
  end

  // A rising edge seen after the synchronizer stages.
  assign ack_edge = sync_q[STAGES-1] & ~sync_q[STAGES];

  initial begin
    if (STAGES < 2) $error("pacer_ack_sync needs at least two stages");
  end
endmodule

// File: rtl/pacer_credit.sv
module pacer_credit
  import pacer_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [7:0]       cfg_offset,
  input  logic             rise_evt,
  input  logic             ack_evt,
  output logic             credit_ok,
  output logic [CNT_W-1:0] cnt,
  output logic             proto_err
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic ack_orphan;
  logic ack_take;
  logic [CNT_W-1:0] window;

  assign window     = CNT_W'(cfg_offset);
  assign ack_orphan = ack_evt && (cnt == '0) && !rise_evt;
  assign ack_take   = ack_evt && !ack_orphan;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      proto_err <= 1'b0;
    end else if (!enable) begin
      cnt       <= '0;
      proto_err <= 1'b0;
    end else begin
      unique case ({rise_evt, ack_take})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
      if (ack_orphan) proto_err <= 1'b1;
    end
  end

  assign credit_ok = enable && (cfg_offset != WIN_ASYNC) && (cnt != CNT_MAX) &&
                     ((cfg_offset == WIN_UNLIM) || (cnt < window));

  // R1: never more outstanding than the window allows
  p_window_limit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && cfg_offset != WIN_UNLIM && $stable(cfg_offset)) |-> (cnt <= window));

  // R9: issue and acknowledge in one cycle cancel out
  p_both_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && rise_evt && ack_evt) |=> (cnt == $past(cnt) || !enable));

  // R10: an ACK with nothing outstanding raises the error
  p_orphan_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && ack_evt && cnt == '0 && !rise_evt) |=> (proto_err || $fell(enable)));
endmodule

// File: rtl/pacer_req_timer.sv
module pacer_req_timer
  import pacer_pkg::*;
#(
  parameter int TW = 8,
  localparam int CW = TW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          active,
  input  logic [TW-1:0] cfg_assert,
  input  logic [TW-1:0] cfg_negate,
  input  logic [TW-1:0] cfg_setup,
  input  logic [TW-1:0] cfg_hold,
  input  logic [CW-1:0] period_cyc,
  input  logic          credit_ok,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [7:0]    in_data,
  input  logic          in_last,
  output logic          req,
  output logic [7:0]    db_out,
  output logic          rise_evt,
  output logic          last_issued
);
  localparam logic [CW-1:0] SAT = '1;

  logic [CW-1:0] since_q [N_SINCE];
  logic [N_SINCE-1:0] restart;
  logic [CW-1:0] hold_need;
  logic pending_q, last_pend_q;
  logic take, rise_ok, fall_now;

  assign hold_need = CW'(cfg_setup) + CW'(cfg_hold);

  // Loading a new byte must not disturb the hold window of the last REQ.
  assign in_ready = active && !pending_q && (since_q[SINCE_RISE] >= hold_need);
  assign take     = in_ready && in_valid;

  assign rise_ok  = active && pending_q && !req && credit_ok &&
                    (since_q[SINCE_LOAD] >= CW'(cfg_setup)) &&
                    (since_q[SINCE_RISE] >= period_cyc) &&
                    (since_q[SINCE_FALL] >= CW'(cfg_negate));
  assign fall_now = req && (since_q[SINCE_RISE] >= CW'(cfg_assert));

  always_comb begin
    restart = '0;
    restart[SINCE_RISE] = rise_ok;
    restart[SINCE_FALL] = fall_now;
    restart[SINCE_LOAD] = take;
  end

  // Saturating elapsed-cycle counters, one per tracked event.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_SINCE; i++) since_q[i] <= SAT;
    end else begin
      for (int i = 0; i < N_SINCE; i++) begin
        if (restart[i])           since_q[i] <= CW'(1);
        else if (since_q[i] != SAT) since_q[i] <= since_q[i] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req         <= 1'b0;
      pending_q   <= 1'b0;
      last_pend_q <= 1'b0;
      last_issued <= 1'b0;
      db_out      <= '0;
    end else begin
      if (rise_ok)       req <= 1'b1;
      else if (fall_now) req <= 1'b0;

      if (take) begin
        pending_q   <= 1'b1;
        last_pend_q <= in_last;
        db_out      <= in_data;
      end else if (rise_ok || !enable) begin
        pending_q   <= 1'b0;
      end

      if (!enable)                      last_issued <= 1'b0;
      else if (rise_ok && last_pend_q)  last_issued <= 1'b1;
    end
  end

  assign rise_evt = rise_ok;

  // R4: pulse high time is honoured
  p_high_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req) |-> ($past(since_q[SINCE_RISE]) >= CW'($past(cfg_assert))));

  // R5: period and negation spacing before each new rise
  p_rise_spacing_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req) |-> (($past(since_q[SINCE_RISE]) >= $past(period_cyc)) &&
                    ($past(since_q[SINCE_FALL]) >= CW'($past(cfg_negate)))));

  // R8: data has settled before REQ rises
  p_data_setup_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req) |-> ($stable(db_out) && ($past(since_q[SINCE_LOAD]) >= CW'($past(cfg_setup)))));

  // R8: data held after REQ rises
  p_data_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(db_out) |-> ($past(since_q[SINCE_RISE]) >= $past(hold_need)));
endmodule

// File: rtl/sync_req_pacer.sv
module sync_req_pacer
  import pacer_pkg::*;
#(
  parameter int TW          = 8,
  parameter int CNT_W       = 12,
  parameter int CLK_PS      = 8000,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [7:0]       cfg_offset,
  input  logic [7:0]       cfg_period,
  input  logic [TW-1:0]    cfg_assert,
  input  logic [TW-1:0]    cfg_negate,
  input  logic [TW-1:0]    cfg_setup,
  input  logic [TW-1:0]    cfg_hold,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  input  logic             in_last,
  input  logic             ack_in,
  output logic             req_out,
  output logic [7:0]       db_out,
  output logic             done,
  output logic [CNT_W-1:0] outstanding,
  output logic             mode_err,
  output logic             proto_err
);
  localparam int CW = TW + 1;
  localparam int unsigned CW_MAX = (32'd1 << CW) - 1;

  function automatic logic [CW-1:0] clamp_cycles(input int unsigned v);
    return (v > CW_MAX) ? '1 : v[CW-1:0];
  endfunction

  logic [CW-1:0] period_cyc;
  logic active, ack_evt, credit_ok, rise_evt, last_issued;

  assign period_cyc = clamp_cycles(period_to_cycles(cfg_period, CLK_PS));
  assign active     = enable && (cfg_offset != WIN_ASYNC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_err <= 1'b0;
    else        mode_err <= enable && (cfg_offset == WIN_ASYNC);
  end

  pacer_ack_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .ack_async (ack_in),
    .ack_edge  (ack_evt)
  );

  pacer_credit #(.CNT_W(CNT_W)) u_credit (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .cfg_offset (cfg_offset),
    .rise_evt   (rise_evt),
    .ack_evt    (ack_evt),
    .credit_ok  (credit_ok),
    .cnt        (outstanding),
    .proto_err  (proto_err)
  );

  pacer_req_timer #(.TW(TW)) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .active      (active),
    .cfg_assert  (cfg_assert),
    .cfg_negate  (cfg_negate),
    .cfg_setup   (cfg_setup),
    .cfg_hold    (cfg_hold),
    .period_cyc  (period_cyc),
    .credit_ok   (credit_ok),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_data     (in_data),
    .in_last     (in_last),
    .req         (req_out),
    .db_out      (db_out),
    .rise_evt    (rise_evt),
    .last_issued (last_issued)
  );

  assign done = enable && last_issued && (outstanding == '0) && !req_out;

  // R2: asynchronous window blocks all traffic
  p_async_block_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && cfg_offset == WIN_ASYNC) |-> (!in_ready && !rise_evt));

  p_async_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && cfg_offset == WIN_ASYNC) |=> mode_err);

  // R7: completion only with balanced pulses
  p_done_balanced_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (outstanding == '0 && !req_out));
endmodule

// File: tb/sync_req_pacer_bench.sv
`timescale 1ns/1ps
module sync_req_pacer_bench;
  localparam int TW = 8;
  localparam int CNT_W = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic [7:0] cfg_offset = 8'd1, cfg_period = 8'd0;
  logic [TW-1:0] cfg_assert = '0, cfg_negate = '0, cfg_setup = '0, cfg_hold = '0;
  logic in_valid = 1'b0, in_last = 1'b0, ack_in = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready, req_out, done, mode_err, proto_err;
  logic [7:0] db_out;
  logic [CNT_W-1:0] outstanding;

  always #4 clk = ~clk;

  sync_req_pacer #(.TW(TW), .CNT_W(CNT_W), .CLK_PS(8000)) u_sync_req_pacer (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_offset(cfg_offset),
    .cfg_period(cfg_period), .cfg_assert(cfg_assert), .cfg_negate(cfg_negate),
    .cfg_setup(cfg_setup), .cfg_hold(cfg_hold), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .in_last(in_last), .ack_in(ack_in),
    .req_out(req_out), .db_out(db_out), .done(done), .outstanding(outstanding),
    .mode_err(mode_err), .proto_err(proto_err)
  );

  int checks = 0, errors = 0;
  int cyc = 0;
  // scenario state
  int rises = 0, acks_sent = 0, ack_limit = 0, ack_dly = 0;
  bit orphan_req = 0;
  bit src_run = 0, fire = 0, mon_en = 0;
  int src_idx = 0, nbytes = 0, cid = 0;
  int e_off = 1, e_a = 0, e_n = 0, e_pc = 0, e_s = 0, e_h = 0;
  bit e_exact = 0;
  int last_rise = -1, last_fall = -1, last_chg = -1;
  logic prev_req = 1'b0;
  logic [7:0] prev_db = '0;

  function automatic int maxi(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic [7:0] bytef(input int c, input int i);
    return 8'((c * 29 + i * 37 + 5) & 255);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Source: drives the stream away from the clock edge.
  initial begin
    forever begin
      @(negedge clk);
      if (fire) src_idx++;
      in_valid = src_run && (src_idx < nbytes);
      in_data  = bytef(cid, src_idx);
      in_last  = (src_idx == nbytes - 1);
      #1 fire = in_valid && in_ready;
    end
  end

  // Initiator model: one ACK pulse per observed REQ.
  initial begin
    forever begin
      @(negedge clk);
      if (orphan_req) begin
        orphan_req = 0;
        ack_in = 1'b1;
        repeat (2) @(negedge clk);
        ack_in = 1'b0;
        @(negedge clk);
      end else if (acks_sent < rises && acks_sent < ack_limit) begin
        repeat (ack_dly) @(negedge clk);
        ack_in = 1'b1;
        repeat (2) @(negedge clk);
        ack_in = 1'b0;
        acks_sent++;
        @(negedge clk);
      end
    end
  end

  // Monitor, sampled mid-cycle after each rising edge.
  always @(posedge clk) begin
    #3;
    cyc++;
    if (mon_en) begin
      if (req_out && !prev_req) begin
        if (last_rise >= 0) begin
          if (e_exact)
            chk((cyc - last_rise) == maxi(maxi(maxi(e_s + e_h, 1) + maxi(e_s, 1), maxi(e_pc, 1)),
                                          maxi(e_a, 1) + maxi(e_n, 1)),
                "R5/R6 exact rise gap", cyc - last_rise,
                maxi(maxi(maxi(e_s + e_h, 1) + maxi(e_s, 1), maxi(e_pc, 1)), maxi(e_a, 1) + maxi(e_n, 1)));
          else
            chk((cyc - last_rise) >= maxi(e_pc, 1), "R5 period spacing", cyc - last_rise, maxi(e_pc, 1));
          chk((cyc - last_fall) >= maxi(e_n, 1), "R5 negation spacing", cyc - last_fall, maxi(e_n, 1));
        end
        chk((cyc - last_chg) >= e_s, "R8 setup", cyc - last_chg, e_s);
        chk(db_out == bytef(cid, rises), "R8 byte order", int'(db_out), int'(bytef(cid, rises)));
        rises++;
        last_rise = cyc;
      end
      if (!req_out && prev_req && last_rise >= 0) begin
        chk((cyc - last_rise) == maxi(e_a, 1), "R4 high width", cyc - last_rise, maxi(e_a, 1));
        last_fall = cyc;
      end
      if (db_out != prev_db && last_rise >= 0)
        chk((cyc - last_rise) >= e_s + e_h, "R8 hold", cyc - last_rise, e_s + e_h);
      if (e_off != 255 && e_off != 0)
        chk(int'(outstanding) <= e_off, "R1 window", int'(outstanding), e_off);
    end
    if (db_out != prev_db) last_chg = cyc;
    prev_req = req_out;
    prev_db  = db_out;
  end

  task automatic start_case(input int off, input int a, input int n, input int p,
                            input int s, input int h, input int nb, input int dly,
                            input int lim, input int c);
    @(negedge clk);
    enable = 1'b0; src_run = 0; mon_en = 0;
    repeat (3) @(negedge clk);
    cfg_offset = 8'(off); cfg_assert = TW'(a); cfg_negate = TW'(n);
    cfg_period = 8'(p); cfg_setup = TW'(s); cfg_hold = TW'(h);
    e_off = off; e_a = a; e_n = n; e_s = s; e_h = h;
    e_pc = (p * 4000 + 7999) / 8000;
    e_exact = (off == 255);
    rises = 0; acks_sent = 0; src_idx = 0; nbytes = nb; cid = c;
    ack_dly = dly; ack_limit = lim;
    last_rise = -1; last_fall = -1;
    mon_en = 1; src_run = 1; enable = 1'b1;
  endtask

  task automatic finish_case(input int nb);
    for (int t = 0; t < 6000 && !(rises == nb && acks_sent == nb); t++) @(negedge clk);
    repeat (8) @(negedge clk);
    chk(rises == nb, "R7 all bytes requested", rises, nb);
    chk(outstanding == '0, "R9 balanced count", int'(outstanding), 0);
    chk(done == 1'b1, "R7 done when balanced", int'(done), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Reset state
    chk(req_out == 1'b0, "R4 reset REQ low", int'(req_out), 0);
    chk(outstanding == '0, "R9 reset count", int'(outstanding), 0);
    chk(done == 1'b0 && mode_err == 1'b0 && proto_err == 1'b0, "R7 reset flags", int'(done), 0);
    chk(in_ready == 1'b0, "R11 ready low while disabled", int'(in_ready), 0);

    // R2: asynchronous window
    start_case(0, 1, 1, 0, 0, 0, 3, 0, 999, 1);
    repeat (20) @(negedge clk);
    chk(mode_err == 1'b1, "R2 mode error", int'(mode_err), 1);
    chk(in_ready == 1'b0, "R2 no load", int'(in_ready), 0);
    chk(rises == 0, "R2 no REQ", rises, 0);

    // R10: orphan ACK
    start_case(4, 1, 1, 0, 0, 0, 0, 0, 999, 2);
    orphan_req = 1;
    repeat (10) @(negedge clk);
    chk(proto_err == 1'b1, "R10 orphan ACK flagged", int'(proto_err), 1);
    chk(outstanding == '0, "R10 orphan ACK discarded", int'(outstanding), 0);
    enable = 1'b0;
    @(negedge clk);
    chk(proto_err == 1'b0, "R10 cleared by disable", int'(proto_err), 0);

    // R1: window of two, ACKs withheld then released one at a time
    start_case(2, 1, 1, 0, 0, 0, 5, 0, 0, 3);
    repeat (60) @(negedge clk);
    chk(rises == 2, "R1 held at window", rises, 2);
    chk(outstanding == 12'd2, "R1 count at window", int'(outstanding), 2);
    chk(in_ready == 1'b0, "R11 ready low with byte waiting", int'(in_ready), 0);
    ack_limit = 1;
    repeat (40) @(negedge clk);
    chk(rises == 3, "R1 one ACK frees one REQ", rises, 3);
    chk(outstanding == 12'd2, "R9 count after ACK", int'(outstanding), 2);
    ack_limit = 999;
    finish_case(5);

    // R3: unlimited window, no ACKs
    start_case(255, 2, 1, 0, 1, 0, 10, 0, 0, 4);
    repeat (200) @(negedge clk);
    chk(rises == 10, "R3 unlimited issue", rises, 10);
    chk(outstanding == 12'd10, "R3 count climbs", int'(outstanding), 10);
    chk(done == 1'b0, "R7 no done with ACKs missing", int'(done), 0);
    ack_limit = 999;
    finish_case(10);

    // Sweep
    for (int oi = 0; oi < 3; oi++)
      for (int a = 1; a <= 3; a += 2)
        for (int n = 1; n <= 2; n++)
          for (int pi = 0; pi < 3; pi++)
            for (int s = 0; s <= 2; s += 2)
              for (int h = 0; h <= 2; h += 2)
                for (int sl = 0; sl < 2; sl++) begin
                  start_case((oi == 0) ? 1 : (oi == 1) ? 3 : 255, a, n,
                             (pi == 0) ? 0 : (pi == 1) ? 5 : 20, s, h, 4,
                             sl * 6, 999, 10 + oi * 97 + a * 13 + n * 7 + pi * 3 + s + h * 5 + sl);
                  finish_case(4);
                end

    enable = 1'b0; mon_en = 0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule